// File: doc/BRIEF.md
# Keyboard Scan Code Wake Detector

This block listens, without ever driving, to the clock and data lines of a PS/2-style keyboard. It assembles every frame the keyboard sends and compares the received byte with a code that software has written into a match register. When a clean frame carries exactly that byte, a sticky wake status flag is raised. The flag is combined with an enable flag to form a wake request that system power logic can use to resume from a low-power state.

The two keyboard lines are asynchronous and pass through a synchronizer. Bits are taken on each falling edge of the synchronized keyboard clock. A frame is a low start bit, eight data bits sent least significant first, an odd parity bit and a high stop bit. The match register sits on the standby power rail. Only the standby power-on reset clears it, so the main reset leaves the programmed code intact. A stall timer drops any partial frame when the keyboard clock stays high too long, so a lost edge cannot leave the receiver misaligned.

Top module: `kbd_wake_detect`

## Requirements
- R1: A frame starts only at a falling edge of the keyboard clock that samples the data line low. A falling edge that samples data high while no frame is in progress is ignored.
- R2: The eight data bits follow the start bit on the next eight falling edges, least significant bit first. A high data level means 1, so a byte sent in reversed bit order does not match.
- R3: The ninth bit after the start bit is an odd parity bit: the eight data bits plus the parity bit hold an odd number of ones. A frame whose parity is wrong never raises the wake status.
- R4: The eleventh bit is a stop bit and must be high. A frame with a low stop bit never raises the wake status, and the next frame is received normally.
- R5: A frame that passes the R3 and R4 checks and carries a byte equal to the match register sets wake_sts_o, three clock cycles after the `clk` edge that first registers the stop-bit falling edge. The flag stays set until it is cleared.
- R6: A write with reg_sel = 1 and bit 5 of reg_wdata set clears wake_sts_o. The same write with bit 5 at 0 has no effect. When a clear and a new match land on the same clock edge, the match wins and the status stays set.
- R7: A write with reg_sel = 2 loads bit 5 of reg_wdata into wake_en_o. wake_req_o is high exactly when both wake_sts_o and wake_en_o are high. The status is still set by a match while the enable is low.
- R8: A write with reg_sel = 0 loads all eight bits of reg_wdata into the match register, which is shown on match_code_o. Only por_n resets it, to MATCH_RST (0x00 by default). rst_n leaves it unchanged.
- R9: If the synchronized keyboard clock stays high for TIMEOUT_CYC clock cycles while a frame is in progress, the partial frame is dropped and the next falling edge with data low starts a new frame.
- R10: rst_n low clears wake_sts_o, wake_en_o and the receiver state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Main reset, active low |
| por_n | input | 1 | Standby power-on reset, active low, also clears the match register |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 2 | Register select: 0 match code, 1 status clear, 2 enable |
| reg_wdata | input | 8 | Register write data |
| match_code_o | output | 8 | Current match code |
| wake_sts_o | output | 1 | Sticky wake status |
| wake_en_o | output | 1 | Wake enable |
| wake_req_o | output | 1 | Wake request, status AND enable |

## Verification
The status clear written by software and the status set produced by a matching frame can land on the same clock edge. The bench provokes this by sending a matching frame and issuing the clear write at each offset from zero to six cycles after the stop-bit clock fall. The status must read 1 for every offset up to the set cycle, including the coincident one, and 0 after it. A constrained random run of bytes, match codes and parity faults is then scored against a reference match function written in the bench.

// File: rtl/kbw_pkg.sv
package kbw_pkg;

    // register port selector
    typedef enum logic [1:0] {
        SEL_CODE = 2'd0,
        SEL_STS  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // extra frame bits around the data byte: start, parity, stop
    localparam int FRAME_OVERHEAD = 3;

endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    // idle level of both keyboard lines is high
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/kbw_frame_rx.sv
module kbw_frame_rx
    import kbw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kclk_s,
    input  logic              kdat_s,
    output logic              byte_vld_o,
    output logic [DATA_W-1:0] byte_o
);

    localparam int LAST_IDX = DATA_W + FRAME_OVERHEAD - 1;
    localparam int PAR_IDX  = DATA_W + 1;
    localparam int CNT_W    = $clog2(LAST_IDX + 1);
    localparam int TMR_W    = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic [TMR_W-1:0]  tmr;
        logic              kclk_prev;
        logic              vld;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.kclk_prev = kclk_s;
        fall           = st_q.kclk_prev & ~kclk_s;

        if (fall) begin
            st_d.tmr = '0;
            if (st_q.cnt == '0) begin
                if (!kdat_s) st_d.cnt = CNT_W'(1);
            end else if (st_q.cnt <= CNT_W'(DATA_W)) begin
                st_d.shreg = {kdat_s, st_q.shreg[DATA_W-1:1]};
                st_d.cnt   = st_q.cnt + CNT_W'(1);
            end else if (st_q.cnt == CNT_W'(PAR_IDX)) begin
                st_d.par = kdat_s;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.cnt = '0;
                st_d.vld = kdat_s & (^{st_q.shreg, st_q.par});
            end
        end else if ((st_q.cnt != '0) && kclk_s) begin
            if (st_q.tmr == TMR_W'(TIMEOUT_CYC - 1)) begin
                st_d.cnt = '0;
                st_d.tmr = '0;
            end else begin
                st_d.tmr = st_q.tmr + TMR_W'(1);
            end
        end else begin
            st_d.tmr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.kclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld_o = st_q.vld;
    assign byte_o     = st_q.shreg;

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && st_q.kclk_prev && !kclk_s && kdat_s) |=> (st_q.cnt == '0));

    // R4
    vld_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> ($past(st_q.cnt) == CNT_W'(LAST_IDX) && st_q.cnt == '0));

    // R9
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && kclk_s && st_q.tmr == TMR_W'(TIMEOUT_CYC - 1)) |=> (st_q.cnt == '0));

    // R3
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

endmodule

// File: rtl/kbw_wake_regs.sv
module kbw_wake_regs
    import kbw_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter int              WAKE_BIT  = 5,
    parameter logic [DATA_W-1:0] MATCH_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    output logic [DATA_W-1:0] code_o,
    output logic              sts_o,
    output logic              en_o
);

    typedef struct packed {
        logic sts;
        logic en;
    } wake_state_t;

    wake_state_t       ws_d, ws_q;
    logic [DATA_W-1:0] code_d, code_q;
    logic              hit;
    logic              clr_req;

    always_comb begin
        hit     = byte_vld && (byte_in == code_q);
        clr_req = we && (sel == SEL_STS) && wdata[WAKE_BIT];

        ws_d = ws_q;
        // a new match takes priority over a clear in the same cycle
        if (hit)          ws_d.sts = 1'b1;
        else if (clr_req) ws_d.sts = 1'b0;
        if (we && sel == SEL_EN) ws_d.en = wdata[WAKE_BIT];

        code_d = code_q;
        if (we && sel == SEL_CODE) code_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= '0;
        else        ws_q <= ws_d;
    end

    // standby domain: only the power-on reset touches the code
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) code_q <= MATCH_RST;
        else        code_q <= code_d;
    end

    assign code_o = code_q;
    assign sts_o  = ws_q.sts;
    assign en_o   = ws_q.en;

    // R5
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ws_q.sts);

    // R6
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !ws_q.sts);

    // R6
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr_req) |=> $stable(ws_q.sts));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(we && sel == SEL_CODE) |=> $stable(code_q));

endmodule

// File: rtl/kbd_wake_detect.sv
module kbd_wake_detect
    import kbw_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         TIMEOUT_CYC = 50000,
    parameter int         WAKE_BIT    = 5,
    parameter logic [7:0] MATCH_RST   = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        kb_clk_i,
    input  logic        kb_dat_i,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  match_code_o,
    output logic        wake_sts_o,
    output logic        wake_en_o,
    output logic        wake_req_o
);

    logic [1:0]        line_s;
    logic              rx_vld;
    logic [DATA_W-1:0] rx_byte;
    reg_sel_e          sel_e;

    assign sel_e = reg_sel_e'(reg_sel);

    kbw_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({kb_clk_i, kb_dat_i}),
        .sync_o  (line_s)
    );

    kbw_frame_rx #(
        .DATA_W      (DATA_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .kclk_s     (line_s[1]),
        .kdat_s     (line_s[0]),
        .byte_vld_o (rx_vld),
        .byte_o     (rx_byte)
    );

    kbw_wake_regs #(
        .DATA_W    (DATA_W),
        .WAKE_BIT  (WAKE_BIT),
        .MATCH_RST (MATCH_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_n    (por_n),
        .we       (reg_we),
        .sel      (sel_e),
        .wdata    (reg_wdata),
        .byte_vld (rx_vld),
        .byte_in  (rx_byte),
        .code_o   (match_code_o),
        .sts_o    (wake_sts_o),
        .en_o     (wake_en_o)
    );

    assign wake_req_o = wake_sts_o & wake_en_o;

endmodule

// File: tb/kbd_wake_detect_bench.sv
module kbd_wake_detect_bench;

    localparam int HALF    = 8;
    localparam int TIMEOUT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       kb_clk_i = 1'b1;
    logic       kb_dat_i = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] match_code_o;
    logic       wake_sts_o, wake_en_o, wake_req_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    kbd_wake_detect #(.TIMEOUT_CYC(TIMEOUT)) u_kbd_wake_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_n        (por_n),
        .kb_clk_i     (kb_clk_i),
        .kb_dat_i     (kb_dat_i),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .match_code_o (match_code_o),
        .wake_sts_o   (wake_sts_o),
        .wake_en_o    (wake_en_o),
        .wake_req_o   (wake_req_o)
    );

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic exp_hit(input logic [7:0] b, input logic [7:0] code,
                                     input logic bad_par, input logic bad_stop);
        return !bad_par && !bad_stop && (b == code);
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic clk_pulse_bit(input logic d);
        kb_dat_i = d;
        kb_clk_i = 1'b1;
        repeat (HALF) @(negedge clk);
        kb_clk_i = 1'b0;
        repeat (HALF) @(negedge clk);
        kb_clk_i = 1'b1;
    endtask

    // clr_off >= 0 issues a status clear that many cycles after the stop fall
    task automatic send_frame(input logic [7:0] b, input logic bad_par,
                              input logic bad_stop, input int clr_off);
        @(negedge clk);
        clk_pulse_bit(1'b0);
        for (int i = 0; i < 8; i++) clk_pulse_bit(b[i]);
        clk_pulse_bit(odd_par(b) ^ bad_par);
        kb_dat_i = ~bad_stop;
        kb_clk_i = 1'b1;
        repeat (HALF) @(negedge clk);
        kb_clk_i = 1'b0;
        for (int i = 0; i < HALF; i++) begin
            if (i == clr_off) begin
                reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h20;
            end else begin
                reg_we = 1'b0; reg_sel = 2'd3;
            end
            @(negedge clk);
        end
        reg_we = 1'b0; reg_sel = 2'd3;
        kb_clk_i = 1'b1;
        kb_dat_i = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        logic [7:0] code, b;
        logic       bp, bs, e;
        void'($urandom(32'd1729));

        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8 R10 reset state
        chk(match_code_o, 8'h00, "R8 code after power-on reset");
        chk({7'd0, wake_sts_o}, 8'd0, "R10 status after reset");
        chk({7'd0, wake_en_o}, 8'd0, "R10 enable after reset");
        chk({7'd0, wake_req_o}, 8'd0, "R7 request after reset");

        reg_wr(2'd0, 8'hA5);
        chk(match_code_o, 8'hA5, "R8 code write");
        reg_wr(2'd2, 8'h20);
        chk({7'd0, wake_en_o}, 8'd1, "R7 enable write");

        send_frame(8'hA5, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R5 match sets status");
        chk({7'd0, wake_req_o}, 8'd1, "R7 request with enable");

        reg_wr(2'd1, 8'hDF);
        chk({7'd0, wake_sts_o}, 8'd1, "R6 clear write with bit5 low ignored");
        reg_wr(2'd1, 8'h20);
        chk({7'd0, wake_sts_o}, 8'd0, "R6 clear write");

        send_frame(8'hA5, 1'b1, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd0, "R3 bad parity no match");
        send_frame(8'hA5, 1'b0, 1'b1, -1);
        chk({7'd0, wake_sts_o}, 8'd0, "R4 bad stop no match");
        send_frame(8'hA5, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R4 frame after bad stop matches");
        reg_wr(2'd1, 8'h20);

        reg_wr(2'd0, 8'h1E);
        send_frame(8'h78, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd0, "R2 reversed bit order no match");
        send_frame(8'h1E, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R2 LSB-first match");
        reg_wr(2'd1, 8'h20);

        // R1 a lone fall with data high before the frame
        @(negedge clk);
        clk_pulse_bit(1'b1);
        repeat (HALF) @(negedge clk);
        send_frame(8'h1E, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R1 high-data fall ignored");
        reg_wr(2'd1, 8'h20);

        reg_wr(2'd2, 8'h00);
        send_frame(8'h1E, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R7 status sets with enable low");
        chk({7'd0, wake_req_o}, 8'd0, "R7 request masked");
        reg_wr(2'd2, 8'hFF);
        chk({7'd0, wake_req_o}, 8'd1, "R7 request after enable");
        reg_wr(2'd1, 8'h20);

        // R9 partial frame then a stall longer than the timeout
        @(negedge clk);
        clk_pulse_bit(1'b0);
        clk_pulse_bit(1'b1);
        clk_pulse_bit(1'b0);
        kb_dat_i = 1'b1;
        repeat (TIMEOUT + 20) @(negedge clk);
        send_frame(8'h1E, 1'b0, 1'b0, -1);
        chk({7'd0, wake_sts_o}, 8'd1, "R9 stall drops partial frame");

        // R10 main reset keeps the code
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk({7'd0, wake_sts_o}, 8'd0, "R10 status cleared by main reset");
        chk({7'd0, wake_en_o}, 8'd0, "R10 enable cleared by main reset");
        chk(match_code_o, 8'h1E, "R8 code survives main reset");
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        chk(match_code_o, 8'h00, "R8 code cleared by power-on reset");

        // R6 clear against set at every nearby cycle
        reg_wr(2'd0, 8'h3C);
        reg_wr(2'd2, 8'h20);
        for (int j = 0; j <= 6; j++) begin
            reg_wr(2'd1, 8'h20);
            send_frame(8'h3C, 1'b0, 1'b0, j);
            chk({7'd0, wake_sts_o}, (j <= 3) ? 8'd1 : 8'd0,
                $sformatf("R6 clear at offset %0d vs set", j));
        end

        // random frames against the reference
        for (int k = 0; k < 40; k++) begin
            b    = 8'($urandom);
            code = ($urandom % 2 == 0) ? b : 8'($urandom);
            bp   = ($urandom % 8 == 0);
            bs   = ($urandom % 10 == 0);
            e    = exp_hit(b, code, bp, bs);
            reg_wr(2'd0, code);
            reg_wr(2'd1, 8'h20);
            send_frame(b, bp, bs, -1);
            chk({7'd0, wake_sts_o}, {7'd0, e},
                $sformatf("R5 R3 R4 random byte %0h code %0h", b, code));
            chk({7'd0, wake_req_o}, {7'd0, e}, "R7 random request");
        end

        done = 1'b1;
        report();
    end

endmodule